// File: doc/BRIEF.md
# Half to Double Precision Widener

This block turns a 16-bit IEEE 754 half-precision word into the 64-bit IEEE 754 double-precision word that holds exactly the same value. Widening never loses information, so the block has no rounding, no exception flags and no arithmetic. It handles every input class: signed zeros, subnormals, normal numbers, infinities and NaNs. Half subnormals have no subnormal counterpart in the wide format. A leading-one search and a left shift renormalise them into ordinary doubles within the same clock.

A word is presented with a valid strobe. The converted word appears on the output exactly one clock later, qualified by its own valid. When no input is valid the output word keeps its last value. The formats are parameters: the widths of the exponent and fraction fields on both sides set the biases and shift distances. The same datapath therefore also widens single precision when the input widths are changed to 8 and 23.

Top module: `fp_widen`

## Requirements
- R1: A synchronous active-high reset drives out_valid low on the next clock edge, whatever in_valid is.
- R2: out_valid is in_valid delayed by exactly one clock. A clock edge with in_valid low leaves out_word unchanged.
- R3: The output sign (bit 63) equals the input sign (bit 15) for every input, including zeros, infinities and NaNs.
- R4: An input whose exponent field (bits 14:10) and fraction field (bits 9:0) are both zero gives an output with bits 62:0 all zero: 0x0000 gives 0x0000000000000000 and 0x8000 gives 0x8000000000000000.
- R5: A normal input (exponent e from 1 to 30) gives output exponent e+1008 in bits 62:52, and the 10-bit fraction placed in bits 51:42 with zeros below. 0x3C00 gives 0x3FF0000000000000 (1.0) and 0x3555 gives 0x3FD5540000000000 (0.333251953125).
- R6: A subnormal input (exponent 0, nonzero fraction with its highest set bit at position p) gives a normal double with exponent 999+p. Its fraction is the input fraction shifted left until that highest bit leaves the field, placed in bits 51:42. 0x0001 gives 0x3E70000000000000 and 0x03FF gives 0x3F0FF80000000000.
- R7: An input with exponent 31 and fraction 0 gives a double infinity with the same sign: 0x7C00 gives 0x7FF0000000000000 and 0xFC00 gives 0xFFF0000000000000.
- R8: An input with exponent 31 and a nonzero fraction gives exponent 2047 with the fraction in bits 51:42, so the output is a NaN. Its quiet bit (bit 51) equals input bit 9. 0x7E00 gives 0x7FF8000000000000 and 0x7C01 gives 0x7FF0040000000000.
- R9: For every one of the 65536 input words that is not a NaN, the output bits equal the double encoding of the value the input encodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies in_word for this cycle |
| in_word | input | 16 | Half-precision input word |
| out_valid | output | 1 | Qualifies out_word, one clock after in_valid |
| out_word | output | 64 | Double-precision result |

## Verification
The bench sweeps all 65536 half words and checks each result against a value it builds with real arithmetic. That sweep catches wrong rebiasing of normals and a missing sign on negative zero, which would turn -0 into +0. It also catches an off-by-one in the renormalising shift: such a shift halves or doubles every subnormal, and it keeps the leading one as a stray fraction bit. Directed words cover the smallest and largest subnormal, where a leading-one search that counts from the wrong end shows first. They also cover infinities and both kinds of NaN. A design that drops the fraction of a special would turn a NaN into an infinity, and one that misplaces it would lose the quiet bit. Further checks cover the hold behaviour when valid is low and a reset during a valid input.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

  // Class of an incoming narrow word, decided from its exponent and fraction.
  typedef enum logic [1:0] {
    K_ZERO = 2'd0,
    K_SUBN = 2'd1,
    K_NORM = 2'd2,
    K_SPEC = 2'd3
  } fpw_kind_e;

endpackage

// File: rtl/fpw_unpack.sv
module fpw_unpack
  import fpw_pkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word,
  output logic              sign,
  output logic [EXP_W-1:0]  exp_f,
  output logic [FRAC_W-1:0] frac_f,
  output fpw_kind_e         kind
);

  assign sign   = word[WORD_W-1];
  assign exp_f  = word[WORD_W-2 -: EXP_W];
  assign frac_f = word[FRAC_W-1:0];

  always_comb begin
    if (exp_f == '0) begin
      kind = (frac_f == '0) ? K_ZERO : K_SUBN;
    end else if (&exp_f) begin
      kind = K_SPEC;
    end else begin
      kind = K_NORM;
    end
  end

endmodule

// File: rtl/fpw_lead.sv
// Priority encoder: number of zeros above the highest set bit.
// An all-zero vector reports W.
module fpw_lead #(
  parameter int W     = 10,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [CNT_W-1:0] lz
);

  always_comb begin
    lz = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) lz = CNT_W'(W - 1 - i);
    end
  end

  // R6: the reported position must hold a one when the vector is nonzero.
  always_comb begin
    if (vec != '0) begin
      a_lead_hit_r6: assert (int'(lz) < W && vec[W - 1 - int'(lz)]);
    end
  end

endmodule

// File: rtl/fpw_norm.sv
// Log-stage barrel shifter: moves the fraction left by lz+1 so that its
// leading one falls out of the field.
module fpw_norm #(
  parameter int W     = 10,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     frac_f,
  input  logic [CNT_W-1:0] lz,
  output logic [W-1:0]     norm_f
);

  localparam int AMT_W = CNT_W + 1;

  logic [AMT_W-1:0] amt;
  logic [W:0]       stg [AMT_W+1];

  assign amt    = AMT_W'(lz) + AMT_W'(1);
  assign stg[0] = {1'b0, frac_f};

  for (genvar g = 0; g < AMT_W; g++) begin : g_stage
    assign stg[g+1] = amt[g] ? (stg[g] << (1 << g)) : stg[g];
  end

  assign norm_f = stg[AMT_W][W-1:0];

  // R6: after the shift the leading one sits just above the field.
  always_comb begin
    if (frac_f != '0) begin
      a_norm_lead_r6: assert (stg[AMT_W][W] == 1'b1);
    end
  end

endmodule

// File: rtl/fpw_pack.sv
module fpw_pack
  import fpw_pkg::*;
#(
  parameter int IN_EXP_W   = 5,
  parameter int IN_FRAC_W  = 10,
  parameter int OUT_EXP_W  = 11,
  parameter int OUT_FRAC_W = 52,
  parameter int CNT_W      = $clog2(IN_FRAC_W + 1),
  localparam int OUT_W     = 1 + OUT_EXP_W + OUT_FRAC_W
) (
  input  logic                 sign,
  input  fpw_kind_e            kind,
  input  logic [IN_EXP_W-1:0]  exp_f,
  input  logic [IN_FRAC_W-1:0] frac_f,
  input  logic [IN_FRAC_W-1:0] norm_f,
  input  logic [CNT_W-1:0]     lz,
  output logic [OUT_W-1:0]     word
);

  localparam int IN_BIAS  = (1 << (IN_EXP_W - 1)) - 1;
  localparam int OUT_BIAS = (1 << (OUT_EXP_W - 1)) - 1;
  localparam int REBIAS   = OUT_BIAS - IN_BIAS;
  localparam int PAD      = OUT_FRAC_W - IN_FRAC_W;

  logic [OUT_EXP_W-1:0]  exp_o;
  logic [IN_FRAC_W-1:0]  top_frac;

  always_comb begin
    unique case (kind)
      K_ZERO: begin
        exp_o    = '0;
        top_frac = '0;
      end
      K_SUBN: begin
        exp_o    = OUT_EXP_W'(REBIAS) - OUT_EXP_W'(lz);
        top_frac = norm_f;
      end
      K_SPEC: begin
        exp_o    = '1;
        top_frac = frac_f;
      end
      default: begin
        exp_o    = OUT_EXP_W'(exp_f) + OUT_EXP_W'(REBIAS);
        top_frac = frac_f;
      end
    endcase
  end

  assign word = {sign, exp_o, top_frac, {PAD{1'b0}}};

endmodule

// File: rtl/fp_widen.sv
module fp_widen
  import fpw_pkg::*;
#(
  parameter int IN_EXP_W   = 5,
  parameter int IN_FRAC_W  = 10,
  parameter int OUT_EXP_W  = 11,
  parameter int OUT_FRAC_W = 52,
  localparam int IN_W      = 1 + IN_EXP_W + IN_FRAC_W,
  localparam int OUT_W     = 1 + OUT_EXP_W + OUT_FRAC_W,
  localparam int CNT_W     = $clog2(IN_FRAC_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_word,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word
);

  logic                 sign;
  logic [IN_EXP_W-1:0]  exp_f;
  logic [IN_FRAC_W-1:0] frac_f;
  fpw_kind_e            kind;
  logic [CNT_W-1:0]     lz;
  logic [IN_FRAC_W-1:0] norm_f;
  logic [OUT_W-1:0]     packed_w;

  fpw_unpack #(.EXP_W(IN_EXP_W), .FRAC_W(IN_FRAC_W)) u_unpack (
    .word(in_word), .sign(sign), .exp_f(exp_f), .frac_f(frac_f), .kind(kind)
  );

  fpw_lead #(.W(IN_FRAC_W), .CNT_W(CNT_W)) u_lead (
    .vec(frac_f), .lz(lz)
  );

  fpw_norm #(.W(IN_FRAC_W), .CNT_W(CNT_W)) u_norm (
    .frac_f(frac_f), .lz(lz), .norm_f(norm_f)
  );

  fpw_pack #(
    .IN_EXP_W(IN_EXP_W), .IN_FRAC_W(IN_FRAC_W),
    .OUT_EXP_W(OUT_EXP_W), .OUT_FRAC_W(OUT_FRAC_W), .CNT_W(CNT_W)
  ) u_pack (
    .sign(sign), .kind(kind), .exp_f(exp_f), .frac_f(frac_f),
    .norm_f(norm_f), .lz(lz), .word(packed_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= packed_w;
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_word));
  p_sign_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_word[OUT_W-1] == $past(in_word[IN_W-1]));
  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word[IN_W-2:0] == '0) |=> out_word[OUT_W-2:0] == '0);
  p_special_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && &in_word[IN_W-2 -: IN_EXP_W]) |=> &out_word[OUT_W-2 -: OUT_EXP_W]);
  p_finite_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(&in_word[IN_W-2 -: IN_EXP_W])) |=> !(&out_word[OUT_W-2 -: OUT_EXP_W]));

endmodule

// File: tb/fp_widen_test.sv
module fp_widen_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] in_word;
  logic        out_valid;
  logic [63:0] out_word;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fp_widen uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_word(out_word)
  );

  function automatic real pow2(int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else        for (int i = 0; i < -k; i++) r = r / 2.0;
    return r;
  endfunction

  // Expected encoding from the value the half word denotes.
  function automatic logic [63:0] expect_bits(logic [15:0] h);
    logic s = h[15];
    int   e = int'(h[14:10]);
    int   f = int'(h[9:0]);
    real  v;
    if (e == 31) return {s, 11'h7FF, h[9:0], 42'd0};
    if (e == 0 && f == 0) return {s, 63'd0};
    if (e == 0) v = real'(f) * pow2(-24);
    else        v = real'(1024 + f) * pow2(e - 25);
    if (s) v = -v;
    return $realtobits(v);
  endfunction

  function automatic string tag_of(logic [15:0] h);
    if (h[14:10] == 5'd31) return (h[9:0] == 0) ? "R7" : "R8";
    if (h[14:10] == 5'd0)  return (h[9:0] == 0) ? "R4" : "R6";
    return "R5";
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // Present one word, then sample the result one clock later.
  task automatic apply(logic [15:0] h, output logic [63:0] got, output logic vld);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = h;
    @(negedge clk);
    in_valid = 1'b0;
    got = out_word;
    vld = out_valid;
  endtask

  task automatic directed(logic [15:0] h, logic [63:0] exp_v, string req);
    logic [63:0] got;
    logic        vld;
    apply(h, got, vld);
    check(vld && got == exp_v, req, got, exp_v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] got;
    logic [63:0] held;
    logic        vld;
    rst = 1'b1;
    in_valid = 1'b1;
    in_word = 16'h3C00;
    repeat (3) @(negedge clk);
    // R1: reset wins over a valid input
    check(out_valid == 1'b0, "R1", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;

    directed(16'h3C00, 64'h3FF0000000000000, "R5");
    directed(16'h3555, 64'h3FD5540000000000, "R5");
    directed(16'h0000, 64'h0000000000000000, "R4");
    directed(16'h8000, 64'h8000000000000000, "R4");
    directed(16'h0001, 64'h3E70000000000000, "R6");
    directed(16'h03FF, 64'h3F0FF80000000000, "R6");
    directed(16'h8001, 64'hBE70000000000000, "R3");
    directed(16'h7C00, 64'h7FF0000000000000, "R7");
    directed(16'hFC00, 64'hFFF0000000000000, "R7");
    directed(16'h7E00, 64'h7FF8000000000000, "R8");
    directed(16'h7C01, 64'h7FF0040000000000, "R8");

    // R2: no valid input, output word held and valid low
    held = out_word;
    in_word = 16'h1234;
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b0 && out_word == held, "R2", out_word, held);

    // R1: reset during a valid input clears the output valid
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;
    in_valid = 1'b0;

    // R9: every half word
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] h;
      logic [63:0] ev;
      bit ok;
      h = 16'(i);
      ev = expect_bits(h);
      apply(h, got, vld);
      if (h[14:10] == 5'd31 && h[9:0] != 0) begin
        ok = vld && got[62:52] == 11'h7FF && got[51:0] != 0 &&
             got[51] == h[9] && got[63] == h[15];
      end else begin
        ok = vld && got == ev;
      end
      check(ok, {"R9/", tag_of(h)}, got, ev);
    end
    finish_run();
  end

endmodule